// File: doc/BRIEF.md
# Masked Packed Multiply-Add Datapath

This SIMD execution unit takes vectors of signed 16-bit words. For each 32-bit result lane it multiplies the two low words together and the two high words together, then adds the two signed products. A 512-bit vector holds up to sixteen such lanes. A length select picks how many lanes are active: 4, 8 or 16. In the masked mode, a per-lane write mask decides lane by lane whether the new result is written. A lane whose mask bit is clear either keeps the previous destination value (merge) or becomes zero (zeroing).

A mode input sets which operands are used and what happens to the destination above the active length. In the two legacy modes the old destination is also the first multiplicand, and bits above the computed part are kept. In the three-operand unmasked mode and in the masked mode, everything above the active length is cleared. The result is registered and appears one cycle after a valid input, together with a valid flag. The surrounding pipeline supplies the old destination value.

Top module: `simd_madd_unit`

## Requirements
- R1: Each active result lane j (bits 32j+31..32j) equals the 32-bit sum of two products of signed 16-bit words. One product is A[32j+15:32j] times B[32j+15:32j]; the other is A[32j+31:32j+16] times B[32j+31:32j+16].
- R2: When all four words feeding a lane are 0x8000, the lane result is 0x80000000. This is the only case in which the sum wraps.
- R3: In modes 2 and 3 the active lane count follows len_i: code 0 gives 4 lanes, code 1 gives 8 lanes, and codes 2 and 3 give 16 lanes.
- R4: In mode 3 with zero_i=0, an active lane whose mask_i bit j is clear keeps its dst_old_i value; a set bit writes the result.
- R5: In mode 3 with zero_i=1, an active lane whose mask_i bit j is clear becomes zero.
- R6: Mode 2 (three-operand unmasked) uses src_a_i as multiplicand A and writes every active lane. mask_i and zero_i have no effect.
- R7: In modes 2 and 3, every destination bit above the active length is zero.
- R8: Mode 1 (legacy 128-bit) computes 4 lanes with dst_old_i as multiplicand A. src_a_i, len_i, mask_i and zero_i are ignored, and bits 511..128 keep their dst_old_i value.
- R9: Mode 0 (legacy 64-bit) computes 2 lanes with dst_old_i as multiplicand A. Bits 511..64 keep their dst_old_i value, and src_a_i, len_i, mask_i and zero_i are ignored.
- R10: dst_o updates one clock after a cycle with in_valid=1. out_valid is in_valid delayed by one clock. When in_valid=0, dst_o holds its value.
- R11: A synchronous active-high rst clears dst_o and out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs valid this cycle |
| mode_i | input | 2 | 0 legacy 64, 1 legacy 128, 2 unmasked three-operand, 3 masked |
| len_i | input | 2 | Vector length: 0=128, 1=256, 2/3=512 bits |
| zero_i | input | 1 | Masked mode: 1 zeroing, 0 merging |
| mask_i | input | 16 | Per-lane write mask, bit j for lane j |
| src_a_i | input | 512 | First source vector (modes 2 and 3) |
| src_b_i | input | 512 | Second source vector |
| dst_old_i | input | 512 | Previous destination value |
| out_valid | output | 1 | dst_o carries a new result |
| dst_o | output | 512 | Registered destination |

## Verification
The clocked properties assume the control inputs are meaningful only on cycles with in_valid=1, and that reset is held for at least one clock before the first valid input. The bench drives all inputs on the falling edge and raises in_valid for single cycles, so every check lines up with one registered result. The sweep covers every mode, length code, mask policy and a set of mask patterns with pseudo-random words. Directed vectors add the all-0x8000 wrap lane and lanes at the extremes of the signed range.

// File: rtl/simd_madd_pkg.sv
package simd_madd_pkg;
   localparam int WORD_W    = 16;
   localparam int LANE_W    = 2 * WORD_W;
   localparam int MAX_LANES = 16;

   typedef enum logic [1:0] {
      MODE_LEG64  = 2'd0,
      MODE_LEG128 = 2'd1,
      MODE_THREE  = 2'd2,
      MODE_MASKED = 2'd3
   } madd_mode_e;

   typedef enum logic [1:0] {
      SEL_KEEP   = 2'd0,
      SEL_ZERO   = 2'd1,
      SEL_RESULT = 2'd2
   } lane_sel_e;
endpackage

// File: rtl/madd_lane.sv
module madd_lane #(
   parameter int WORD_W = 16,
   localparam int LANE_W = 2 * WORD_W
) (
   input  logic [LANE_W-1:0] a_i,
   input  logic [LANE_W-1:0] b_i,
   output logic [LANE_W-1:0] sum_o
);
   initial begin
      assert (WORD_W >= 2) else $error("madd_lane: WORD_W too small");
   end

   logic signed [WORD_W-1:0] a_lo, a_hi, b_lo, b_hi;
   logic signed [LANE_W-1:0] prod_lo, prod_hi;

   always_comb begin
      a_lo    = a_i[WORD_W-1:0];
      a_hi    = a_i[LANE_W-1:WORD_W];
      b_lo    = b_i[WORD_W-1:0];
      b_hi    = b_i[LANE_W-1:WORD_W];
      prod_lo = a_lo * b_lo;
      prod_hi = a_hi * b_hi;
      sum_o   = prod_lo + prod_hi;
   end

   localparam logic [WORD_W-1:0] MOST_NEG = {1'b1, {(WORD_W-1){1'b0}}};

   // R2: four most-negative words give exactly the wrapped value
   always_comb begin
      if (a_lo == MOST_NEG && a_hi == MOST_NEG && b_lo == MOST_NEG && b_hi == MOST_NEG)
         p_wrap_r2: assert (sum_o == {1'b1, {(LANE_W-1){1'b0}}});
   end
endmodule

// File: rtl/madd_span.sv
module madd_span
   import simd_madd_pkg::*;
#(
   parameter int MAX_LANES = 16,
   localparam int CNT_W = $clog2(MAX_LANES + 1)
) (
   input  logic [1:0]       mode_i,
   input  logic [1:0]       len_i,
   output logic [CNT_W-1:0] active_o,
   output logic             keep_upper_o,
   output logic             use_mask_o,
   output logic             a_from_dst_o
);
   initial begin
      assert (MAX_LANES >= 4) else $error("madd_span: MAX_LANES below 4");
   end

   localparam int LEN_CODES = 4;

   logic [CNT_W-1:0] len_count [LEN_CODES];

   for (genvar c = 0; c < LEN_CODES; c++) begin : g_len
      localparam int RAW = (c > 2) ? 16 : (4 << c);
      localparam int CNT = (RAW > MAX_LANES) ? MAX_LANES : RAW;
      assign len_count[c] = CNT_W'(CNT);
   end

   always_comb begin
      active_o     = len_count[len_i];
      keep_upper_o = 1'b0;
      use_mask_o   = 1'b0;
      a_from_dst_o = 1'b0;
      unique case (madd_mode_e'(mode_i))
         MODE_LEG64: begin
            active_o     = CNT_W'(2);
            keep_upper_o = 1'b1;
            a_from_dst_o = 1'b1;
         end
         MODE_LEG128: begin
            active_o     = CNT_W'(4);
            keep_upper_o = 1'b1;
            a_from_dst_o = 1'b1;
         end
         MODE_THREE:  ;
         MODE_MASKED: use_mask_o = 1'b1;
         default:     ;
      endcase
   end

   // R3: active count never exceeds the lane array
   always_comb begin
      p_span_r3: assert (active_o <= CNT_W'(MAX_LANES) && active_o >= CNT_W'(2));
   end
endmodule

// File: rtl/madd_merge.sv
module madd_merge
   import simd_madd_pkg::*;
#(
   parameter int LANE_W = 32
) (
   input  logic              active_i,
   input  logic              keep_upper_i,
   input  logic              use_mask_i,
   input  logic              zero_i,
   input  logic              mask_bit_i,
   input  logic [LANE_W-1:0] result_i,
   input  logic [LANE_W-1:0] old_i,
   output logic [LANE_W-1:0] lane_o
);
   lane_sel_e sel;

   always_comb begin
      if (!active_i)
         sel = keep_upper_i ? SEL_KEEP : SEL_ZERO;
      else if (use_mask_i && !mask_bit_i)
         sel = zero_i ? SEL_ZERO : SEL_KEEP;
      else
         sel = SEL_RESULT;
   end

   always_comb begin
      unique case (sel)
         SEL_KEEP:   lane_o = old_i;
         SEL_ZERO:   lane_o = '0;
         SEL_RESULT: lane_o = result_i;
         default:    lane_o = '0;
      endcase
   end
endmodule

// File: rtl/simd_madd_unit.sv
module simd_madd_unit
   import simd_madd_pkg::*;
#(
   parameter int WORD_W    = simd_madd_pkg::WORD_W,
   parameter int MAX_LANES = simd_madd_pkg::MAX_LANES,
   localparam int LANE_W   = 2 * WORD_W,
   localparam int VEC_W    = MAX_LANES * LANE_W,
   localparam int CNT_W    = $clog2(MAX_LANES + 1)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [1:0]           mode_i,
   input  logic [1:0]           len_i,
   input  logic                 zero_i,
   input  logic [MAX_LANES-1:0] mask_i,
   input  logic [VEC_W-1:0]     src_a_i,
   input  logic [VEC_W-1:0]     src_b_i,
   input  logic [VEC_W-1:0]     dst_old_i,
   output logic                 out_valid,
   output logic [VEC_W-1:0]     dst_o
);
   initial begin
      assert (WORD_W == 16) else $error("simd_madd_unit: WORD_W must be 16");
      assert (MAX_LANES == 16) else $error("simd_madd_unit: MAX_LANES must be 16");
   end

   logic [CNT_W-1:0] active_cnt;
   logic             keep_upper, use_mask, a_from_dst;
   logic [VEC_W-1:0] mult_a, lanes_next;

   madd_span #(.MAX_LANES(MAX_LANES)) u_span (
      .mode_i       (mode_i),
      .len_i        (len_i),
      .active_o     (active_cnt),
      .keep_upper_o (keep_upper),
      .use_mask_o   (use_mask),
      .a_from_dst_o (a_from_dst)
   );

   assign mult_a = a_from_dst ? dst_old_i : src_a_i;

   for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
      logic [LANE_W-1:0] sum;
      logic              act;

      assign act = (CNT_W'(j) < active_cnt);

      madd_lane #(.WORD_W(WORD_W)) u_lane (
         .a_i   (mult_a[j*LANE_W +: LANE_W]),
         .b_i   (src_b_i[j*LANE_W +: LANE_W]),
         .sum_o (sum)
      );

      madd_merge #(.LANE_W(LANE_W)) u_merge (
         .active_i     (act),
         .keep_upper_i (keep_upper),
         .use_mask_i   (use_mask),
         .zero_i       (zero_i),
         .mask_bit_i   (mask_i[j]),
         .result_i     (sum),
         .old_i        (dst_old_i[j*LANE_W +: LANE_W]),
         .lane_o       (lanes_next[j*LANE_W +: LANE_W])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         dst_o     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) dst_o <= lanes_next;
      end
   end

   // R10: valid flag tracks input valid by one clock
   p_valid_r10: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   // R10: output holds when no input is valid
   p_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(dst_o));
   // R7: shortest length in cleared modes leaves the top zero
   p_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode_i[1] && len_i == 2'd0) |=> (dst_o[VEC_W-1:4*LANE_W] == '0));
   // R8: legacy 128 keeps bits above 128
   p_keep_r8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode_i == 2'd1) |=> (dst_o[VEC_W-1:4*LANE_W] == $past(dst_old_i[VEC_W-1:4*LANE_W])));
   // R5: zeroing clears a masked-off lane 0
   p_zero_lane_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode_i == 2'd3 && zero_i && !mask_i[0]) |=> (dst_o[LANE_W-1:0] == '0));
   // R11: reset clears state
   p_reset_r11: assert property (@(posedge clk)
      rst |=> (!out_valid && dst_o == '0));
endmodule

// File: tb/simd_madd_unit_bench.sv
module simd_madd_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int VW = 512;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           in_valid = 1'b0;
   logic [1:0]     mode_i = '0, len_i = '0;
   logic           zero_i = 1'b0;
   logic [15:0]    mask_i = '0;
   logic [VW-1:0]  src_a_i = '0, src_b_i = '0, dst_old_i = '0;
   logic           out_valid;
   logic [VW-1:0]  dst_o;

   int total = 0, bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   simd_madd_unit u_simd_madd_unit (
      .clk(clk), .rst(rst), .in_valid(in_valid), .mode_i(mode_i), .len_i(len_i),
      .zero_i(zero_i), .mask_i(mask_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
      .dst_old_i(dst_old_i), .out_valid(out_valid), .dst_o(dst_o)
   );

   function automatic logic [VW-1:0] model(input logic [1:0] m, input logic [1:0] l,
      input logic z, input logic [15:0] k, input logic [VW-1:0] a,
      input logic [VW-1:0] b, input logic [VW-1:0] d);
      logic [VW-1:0] r;
      logic [VW-1:0] aa;
      int n;
      aa = (m < 2) ? d : a;
      n  = (m == 0) ? 2 : (m == 1) ? 4 : (l == 0) ? 4 : (l == 1) ? 8 : 16;
      for (int j = 0; j < 16; j++) begin
         int p0, p1;
         logic [31:0] s;
         p0 = int'($signed(aa[32*j +: 16])) * int'($signed(b[32*j +: 16]));
         p1 = int'($signed(aa[32*j+16 +: 16])) * int'($signed(b[32*j+16 +: 16]));
         s  = 32'(p0 + p1);
         if (j >= n)                 r[32*j +: 32] = (m < 2) ? d[32*j +: 32] : 32'h0;
         else if (m == 3 && !k[j])   r[32*j +: 32] = z ? 32'h0 : d[32*j +: 32];
         else                        r[32*j +: 32] = s;
      end
      return r;
   endfunction

   function automatic logic [VW-1:0] rnd_vec();
      logic [VW-1:0] v;
      for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
      return v;
   endfunction

   task automatic check(input string tag, input logic [VW-1:0] got, input logic [VW-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic run(input string tag, input logic [1:0] m, input logic [1:0] l, input logic z,
                      input logic [15:0] k, input logic [VW-1:0] a, input logic [VW-1:0] b,
                      input logic [VW-1:0] d);
      @(negedge clk);
      mode_i = m; len_i = l; zero_i = z; mask_i = k;
      src_a_i = a; src_b_i = b; dst_old_i = d; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(tag, dst_o, model(m, l, z, k, a, b, d));
      total++;
      if (out_valid !== 1'b1) begin
         bad++;
         $display("FAIL R10 out_valid got=%b exp=1", out_valid);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] masks [4];
      logic [VW-1:0] a, b, d, held;
      string tag;
      void'($urandom(32'h1234));
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 dst_o", dst_o, '0);
      check("R11 out_valid", {511'b0, out_valid}, '0);
      rst = 1'b0;

      // R1 known values: (3*-2)+(-5*7) = -41; extremes: (-32768*32767)+(32767*32767)
      a = '0; b = '0;
      a[31:0] = {16'hFFFB, 16'h0003}; b[31:0] = {16'h0007, 16'hFFFE};
      a[63:32] = {16'h7FFF, 16'h8000}; b[63:32] = {16'h7FFF, 16'h7FFF};
      run("R1 known", 2'd2, 2'd2, 1'b0, 16'h0, a, b, '0);
      check("R1 lane0", {480'b0, dst_o[31:0]}, {480'b0, 32'hFFFFFFD7});
      check("R1 lane1", {480'b0, dst_o[63:32]}, {480'b0, 32'hFFFF8001});

      // R2 wrap lane
      a = {16{32'h80008000}}; b = a;
      run("R2 wrap", 2'd3, 2'd2, 1'b0, 16'hFFFF, a, b, rnd_vec());
      check("R2 lane value", {480'b0, dst_o[31:0]}, {480'b0, 32'h80000000});

      // R10 hold: new data without valid must not change the output
      held = dst_o;
      @(negedge clk);
      src_b_i = rnd_vec(); mode_i = 2'd2;
      @(negedge clk);
      check("R10 hold", dst_o, held);
      total++;
      if (out_valid !== 1'b0) begin
         bad++;
         $display("FAIL R10 out_valid got=%b exp=0", out_valid);
      end

      masks[0] = 16'hFFFF; masks[1] = 16'h0000; masks[2] = 16'hA5C3;
      for (int m = 0; m < 4; m++)
         for (int l = 0; l < 4; l++)
            for (int z = 0; z < 2; z++)
               for (int k = 0; k < 4; k++)
                  for (int r = 0; r < 3; r++) begin
                     masks[3] = 16'($urandom);
                     a = rnd_vec(); b = rnd_vec(); d = rnd_vec();
                     if (r == 2) begin
                        // corner lanes at the signed limits (R1, R2)
                        a[31:0] = 32'h80008000; b[31:0] = 32'h80008000;
                        d[31:0] = 32'h80008000;
                        a[95:64] = 32'h7FFF8000; b[95:64] = 32'h80007FFF;
                     end
                     case (m)
                        0: tag = "R9 legacy64";
                        1: tag = "R8 legacy128";
                        2: tag = "R6 R3 R7 unmasked";
                        default: tag = z ? "R5 R3 R7 zeroing" : "R4 R3 R7 merging";
                     endcase
                     run(tag, 2'(m), 2'(l), 1'(z), masks[k], a, b, d);
                  end

      // R11 reset mid-run clears the output
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      check("R11 after reset", dst_o, '0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule